// File: doc/BRIEF.md
# Legacy System Board Control Ports

This block is the byte-wide, I/O-mapped control register set of a legacy PC system board. A host bus presents a 16-bit port address, an 8-bit write byte and separate read and write strobes, one transfer per clock. The block decodes a small set of port addresses. Writes update its registers. Reads return register contents on a combinational data path in the same cycle as the read strobe.

The block drives the board-level controls that those registers own:
- an alternate A20 gate level;
- a single-clock CPU soft-reset pulse;
- the enable for the first serial port;
- the enable and the base-address select for the parallel port;
- two enables that route low memory regions either to on-board RAM or to the external bus.

The memory-region enables come from a 256-entry byte array. Software reaches that array through an index port and a data port.

Top module: `sysctl_board_ctl`

## Requirements
- R1: A read of port 0x0091 returns 0x00.
- R2: A read of port 0x00E0, or of any port the block does not decode, returns 0xFF. While the read strobe is low, the read data is also 0xFF.
- R3: A write to port 0x0092 with bit 0 set drives `cpu_reset` high for exactly the one clock cycle that follows the write edge. A write with bit 0 clear gives no pulse. Bit 0 always reads back as 0.
- R4: Bit 1 of the last byte written to port 0x0092 drives `a20_alt`. Bits 7:1 read back as written.
- R5: Bit 2 of port 0x0102 drives `serial_en` (1 = first serial port enabled).
- R6: Bits 6:5 of port 0x0102 drive `par_base_sel`, where 0 selects base 0x3BC, 1 selects 0x378 and 2 selects 0x278. `par_en` is high only when bit 4 is set and bits 6:5 are not 3.
- R7: A write to port 0x00E0 latches an 8-bit index. Reads and writes of port 0x00E1 access the entry of a 256-entry byte array at that index.
- R8: Bit 0 of array entry 0 drives `ram_lo_en` (region 0x00000-0x7FFFF on-board). Bit 0 of entry 1 drives `ram_mid_en` (region 0x80000-0x9FFFF on-board). A clear bit routes the region to the external bus. No other entry affects either output.
- R9: A read of port 0x0105 returns the stored byte with bit 7 forced to 1.
- R10: After reset, every register and array entry is 0x00 except port 0x0102, which is 0x10. The outputs are then: parallel port enabled at select 0, serial port disabled, `a20_alt` low, both RAM enables low, no reset pulse.
- R11: Ports 0x0094, 0x0103, 0x0104 and 0x0190 are plain 8-bit read/write registers. Port 0x0102 also reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Port address |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read byte, combinational, valid while `bus_rd` is high |
| a20_alt | output | 1 | Alternate A20 gate level |
| cpu_reset | output | 1 | One-cycle CPU soft-reset pulse |
| serial_en | output | 1 | First serial port enable |
| par_en | output | 1 | Parallel port enable |
| par_base_sel | output | 2 | Parallel base select: 0=0x3BC, 1=0x378, 2=0x278 |
| ram_lo_en | output | 1 | On-board RAM enable, 0x00000-0x7FFFF |
| ram_mid_en | output | 1 | On-board RAM enable, 0x80000-0x9FFFF |

## Verification
The checker verifies a set of properties on every cycle:
- each reset pulse traces back to a write of port 0x0092 with bit 0 set;
- `a20_alt` and `serial_en` take the bit most recently written to them;
- the fixed read values of ports 0x0091 and 0x0105, the cleared bit 0 of port 0x0092 and the all-ones reply for undecoded ports all hold;
- the parallel enable is never high with select value 3.

Only the bench scenarios can show the remaining behaviour: that the pulse lasts exactly one cycle, that plain registers retain data, that the indexed array stores separate entries, and that entries other than 0 and 1 leave the RAM enables alone.

// File: rtl/sysctl_pkg.sv
// Package: shared port map, widths and decode type for the system board
// control block. Assumes a 16-bit I/O address and byte-wide data.
package sysctl_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int NCFG    = 4;

    localparam logic [ADDR_W-1:0] P_ZERO  = 16'h0091;
    localparam logic [ADDR_W-1:0] P_CTL   = 16'h0092;
    localparam logic [ADDR_W-1:0] P_MISC  = 16'h0094;
    localparam logic [ADDR_W-1:0] P_INDEX = 16'h00E0;
    localparam logic [ADDR_W-1:0] P_DATA  = 16'h00E1;
    localparam logic [ADDR_W-1:0] P_CFG0  = 16'h0102;
    localparam logic [ADDR_W-1:0] P_GEN   = 16'h0190;

    localparam logic [DATA_W-1:0] CFG0_RST = 8'h10;
    localparam logic [DATA_W-1:0] RD_IDLE  = 8'hFF;

    // One select per decoded port; at most one is high.
    typedef struct packed {
        logic            zero;
        logic            ctl;
        logic            misc;
        logic            index;
        logic            data;
        logic [NCFG-1:0] cfg;
        logic            gen;
    } sel_t;
endpackage

// File: rtl/sysctl_addr_dec.sv
// Address decoder: turns the 16-bit port address into one select per
// register. Assumes the adapter-setup ports occupy NCFG consecutive
// addresses starting at P_CFG0.
module sysctl_addr_dec
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    // Fixed single-address ports.
    always_comb begin
        sel.zero  = (addr == P_ZERO);
        sel.ctl   = (addr == P_CTL);
        sel.misc  = (addr == P_MISC);
        sel.index = (addr == P_INDEX);
        sel.data  = (addr == P_DATA);
        sel.gen   = (addr == P_GEN);
    end

    // Consecutive adapter-setup ports.
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam logic [ADDR_W-1:0] PA = P_CFG0 + ADDR_W'(g);
        assign sel.cfg[g] = (addr == PA);
    end
endmodule

// File: rtl/sysctl_reset_ctl.sv
// Fast-A20 / soft-reset port. Bit 0 of a write fires a one-clock reset pulse
// and is never stored. Bit 1 drives the alternate A20 gate. Assumes the
// write strobe lasts one cycle per transfer.
module sysctl_reset_ctl
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_q,
    output logic              a20_alt,
    output logic              cpu_reset
);
    // Store the written byte with the reset-request bit cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_sel) ctl_q <= {wdata[DATA_W-1:1], 1'b0};
    end

    // Register the pulse so it lasts exactly the cycle after the write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_reset <= 1'b0;
        else        cpu_reset <= wr_sel & wdata[0];
    end

    assign a20_alt = ctl_q[1];
endmodule

// File: rtl/sysctl_adapter_cfg.sv
// Adapter-setup register group. Register 0 controls the serial enable and
// the parallel enable/base select; the others are plain storage. Assumes
// select value 3 means no valid parallel base.
module sysctl_adapter_cfg
    import sysctl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCFG-1:0]             wr_sel,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NCFG-1:0][DATA_W-1:0] cfg_q,
    output logic                        serial_en,
    output logic                        par_en,
    output logic [1:0]                  par_base_sel
);
    localparam int SER_BIT  = 2;
    localparam int PAR_BIT  = 4;
    localparam int BASE_LSB = 5;

    for (genvar g = 0; g < NCFG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RV = (g == 0) ? CFG0_RST : '0;
        // One storage byte per setup port, with its own reset value.
        always_ff @(posedge clk) begin
            if (!rst_n)         cfg_q[g] <= RV;
            else if (wr_sel[g]) cfg_q[g] <= wdata;
        end
    end

    // Decode the peripheral controls from register 0.
    always_comb begin
        serial_en    = cfg_q[0][SER_BIT];
        par_base_sel = cfg_q[0][BASE_LSB+1:BASE_LSB];
        par_en       = cfg_q[0][PAR_BIT] && (par_base_sel != 2'd3);
    end
endmodule

// File: rtl/sysctl_index_bank.sv
// Indexed register array: an index latch plus a DEPTH-entry byte array
// reached through a data port. Bit 0 of entries 0 and 1 gates the two
// on-board RAM regions. Assumes DEPTH is 2**IDX_W and at least 2.
module sysctl_index_bank
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_index,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_entry,
    output logic              ram_lo_en,
    output logic              ram_mid_en
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] bank [DEPTH];

    // Latch the index from the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)        idx_q <= '0;
        else if (wr_index) idx_q <= wdata[IDX_W-1:0];
    end

    // Write the selected entry; clear every entry on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
        end else if (wr_data) begin
            bank[idx_q] <= wdata;
        end
    end

    assign rd_entry   = bank[idx_q];
    assign ram_lo_en  = bank[0][0];
    assign ram_mid_en = bank[1][0];
endmodule

// File: rtl/sysctl_board_ctl.sv
// Top of the system board control ports. Decodes the port address, routes
// writes to the register groups, holds the miscellaneous and general bytes,
// and muxes read data. Assumes a single-cycle strobe bus; reads have no side
// effects.
module sysctl_board_ctl
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              a20_alt,
    output logic              cpu_reset,
    output logic              serial_en,
    output logic              par_en,
    output logic [1:0]        par_base_sel,
    output logic              ram_lo_en,
    output logic              ram_mid_en
);
    localparam logic [DATA_W-1:0] FORCE_105 = 8'h80;

    sel_t                        sel;
    logic [DATA_W-1:0]           ctl_q, misc_q, gen_q, entry_q;
    logic [NCFG-1:0][DATA_W-1:0] cfg_q;

    sysctl_addr_dec i_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    sysctl_reset_ctl i_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (bus_wr & sel.ctl),
        .wdata     (bus_wdata),
        .ctl_q     (ctl_q),
        .a20_alt   (a20_alt),
        .cpu_reset (cpu_reset)
    );

    sysctl_adapter_cfg i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_sel       ({NCFG{bus_wr}} & sel.cfg),
        .wdata        (bus_wdata),
        .cfg_q        (cfg_q),
        .serial_en    (serial_en),
        .par_en       (par_en),
        .par_base_sel (par_base_sel)
    );

    sysctl_index_bank #(.IDX_W(IDX_W)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_index   (bus_wr & sel.index),
        .wr_data    (bus_wr & sel.data),
        .wdata      (bus_wdata),
        .rd_entry   (entry_q),
        .ram_lo_en  (ram_lo_en),
        .ram_mid_en (ram_mid_en)
    );

    // Plain storage for the miscellaneous and general byte ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misc_q <= '0;
            gen_q  <= '0;
        end else if (bus_wr) begin
            if (sel.misc) misc_q <= bus_wdata;
            if (sel.gen)  gen_q  <= bus_wdata;
        end
    end

    // Read mux; anything not listed (including the index port) reads all ones.
    always_comb begin
        bus_rdata = RD_IDLE;
        if (bus_rd) begin
            if (sel.zero)        bus_rdata = '0;
            else if (sel.ctl)    bus_rdata = ctl_q;
            else if (sel.misc)   bus_rdata = misc_q;
            else if (sel.data)   bus_rdata = entry_q;
            else if (sel.gen)    bus_rdata = gen_q;
            else if (sel.cfg[3]) bus_rdata = cfg_q[3] | FORCE_105;
            else begin
                for (int k = 0; k < NCFG - 1; k++)
                    if (sel.cfg[k]) bus_rdata = cfg_q[k];
            end
        end
    end
endmodule

// File: rtl/sysctl_board_ctl_chk.sv
// Checker for sysctl_board_ctl: per-cycle properties on ports only, bound
// into every instance of the top.
module sysctl_board_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_rdata,
    input logic        a20_alt,
    input logic        cpu_reset,
    input logic        serial_en,
    input logic        par_en,
    input logic [1:0]  par_base_sel
);
    logic known;
    assign known = (bus_addr == 16'h0091) || (bus_addr == 16'h0092) ||
                   (bus_addr == 16'h0094) || (bus_addr == 16'h00E1) ||
                   (bus_addr == 16'h0190) ||
                   (bus_addr >= 16'h0102 && bus_addr <= 16'h0105);

    p_zero_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 16'h0091) |-> bus_rdata == 8'h00);

    p_undecoded_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !known) |-> bus_rdata == 8'hFF);

    p_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset |-> $past(bus_wr && bus_addr == 16'h0092 && bus_wdata[0]));

    p_ctl_bit0_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 16'h0092) |-> !bus_rdata[0]);

    p_a20_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == 16'h0092) |-> a20_alt == $past(bus_wdata[1]));

    p_serial_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == 16'h0102) |-> serial_en == $past(bus_wdata[2]));

    p_no_base3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_base_sel == 2'd3) |-> !par_en);

    p_bit7_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 16'h0105) |-> bus_rdata[7]);
endmodule

bind sysctl_board_ctl sysctl_board_ctl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .a20_alt      (a20_alt),
    .cpu_reset    (cpu_reset),
    .serial_en    (serial_en),
    .par_en       (par_en),
    .par_base_sel (par_base_sel)
);

// File: tb/test_sysctl_board_ctl.sv
// Bench: a vector table of writes and checked reads, then directed tests.
module test_sysctl_board_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        a20_alt, cpu_reset, serial_en, par_en, ram_lo_en, ram_mid_en;
    logic [1:0]  par_base_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sysctl_board_ctl i_sysctl_board_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .a20_alt(a20_alt), .cpu_reset(cpu_reset), .serial_en(serial_en),
        .par_en(par_en), .par_base_sel(par_base_sel),
        .ram_lo_en(ram_lo_en), .ram_mid_en(ram_mid_en)
    );

    // wr=1: write d to a; wr=0: read a, expect d. req names the requirement.
    typedef struct packed {
        logic        wr;
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0091, 8'h00, 8'd1},   // R1
        '{1'b0, 16'h0093, 8'hFF, 8'd2},   // R2
        '{1'b0, 16'h00E0, 8'hFF, 8'd2},   // R2
        '{1'b0, 16'h0320, 8'hFF, 8'd2},   // R2
        '{1'b0, 16'h0102, 8'h10, 8'd10},  // R10
        '{1'b0, 16'h0105, 8'h80, 8'd9},   // R9 after reset
        '{1'b1, 16'h0094, 8'hA5, 8'd11},
        '{1'b0, 16'h0094, 8'hA5, 8'd11},  // R11
        '{1'b1, 16'h0190, 8'h3C, 8'd11},
        '{1'b0, 16'h0190, 8'h3C, 8'd11},  // R11
        '{1'b1, 16'h0103, 8'h11, 8'd11},
        '{1'b0, 16'h0103, 8'h11, 8'd11},  // R11
        '{1'b1, 16'h0104, 8'hEE, 8'd11},
        '{1'b0, 16'h0104, 8'hEE, 8'd11},  // R11
        '{1'b1, 16'h0105, 8'h05, 8'd9},
        '{1'b0, 16'h0105, 8'h85, 8'd9},   // R9
        '{1'b1, 16'h0092, 8'hF3, 8'd3},
        '{1'b0, 16'h0092, 8'hF2, 8'd3},   // R3 bit 0 not stored
        '{1'b1, 16'h00E0, 8'h07, 8'd7},
        '{1'b1, 16'h00E1, 8'h5A, 8'd7},
        '{1'b1, 16'h00E0, 8'h08, 8'd7},
        '{1'b1, 16'h00E1, 8'hC3, 8'd7},
        '{1'b0, 16'h00E1, 8'hC3, 8'd7},   // R7
        '{1'b1, 16'h00E0, 8'h07, 8'd7},
        '{1'b0, 16'h00E1, 8'h5A, 8'd7},   // R7 separate entries
        '{1'b1, 16'h00E0, 8'hFF, 8'd7},
        '{1'b0, 16'h00E1, 8'h00, 8'd7}    // R7 last entry cleared at reset
    };

    task automatic check(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Write one byte: strobe through one rising edge, then release.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Read one byte mid-cycle and compare.
    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, $sformatf("read %04h", a), bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic outs(input int req, input logic [6:0] exp);
        // exp = {a20, rst, ser, par, sel[1:0], lo} ; ram_mid checked separately
        check(req, "outputs", {a20_alt, cpu_reset, serial_en, par_en, par_base_sel, ram_lo_en}, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        outs(10, 7'b0001_00_0);
        check(10, "ram_mid_en", ram_mid_en, 0);
        // R2 idle read data
        bus_addr = 16'h0091; #1;
        check(2, "idle rdata", bus_rdata, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
            else rd(VECS[i].a, VECS[i].d, int'(VECS[i].req));
        end

        // R3 pulse timing: high one cycle after the write edge, then low
        @(negedge clk);
        bus_addr = 16'h0092; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(3, "pulse cycle 1", cpu_reset, 1);
        check(4, "a20 after 0x01", a20_alt, 0);   // R4
        @(negedge clk);
        check(3, "pulse cycle 2", cpu_reset, 0);
        wr(16'h0092, 8'h02);
        check(3, "no pulse bit0 clear", cpu_reset, 0);
        check(4, "a20 set", a20_alt, 1);          // R4
        rd(16'h0092, 8'h02, 3);

        // R5 / R6 adapter controls
        wr(16'h0102, 8'h04);
        check(5, "serial on", serial_en, 1);
        check(6, "par off", par_en, 0);
        wr(16'h0102, 8'h30);
        check(5, "serial off", serial_en, 0);
        check(6, "par sel1", {par_en, par_base_sel}, 3'b101);
        wr(16'h0102, 8'h50);
        check(6, "par sel2", {par_en, par_base_sel}, 3'b110);
        wr(16'h0102, 8'h70);
        check(6, "par sel3 off", {par_en, par_base_sel}, 3'b011);
        wr(16'h0102, 8'h14);
        check(6, "par sel0", {par_en, par_base_sel}, 3'b100);
        rd(16'h0102, 8'h14, 11);

        // R8 memory region enables
        wr(16'h00E0, 8'h00); wr(16'h00E1, 8'h01);
        check(8, "lo on", {ram_lo_en, ram_mid_en}, 2'b10);
        wr(16'h00E0, 8'h01); wr(16'h00E1, 8'hFF);
        check(8, "mid on", {ram_lo_en, ram_mid_en}, 2'b11);
        wr(16'h00E0, 8'h02); wr(16'h00E1, 8'h00);
        check(8, "entry 2 no effect", {ram_lo_en, ram_mid_en}, 2'b11);
        wr(16'h00E0, 8'h00); wr(16'h00E1, 8'hFE);
        check(8, "lo off", {ram_lo_en, ram_mid_en}, 2'b01);

        // R10 reset again restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        outs(10, 7'b0001_00_0);
        check(10, "ram_mid_en after reset", ram_mid_en, 0);
        rd(16'h0094, 8'h00, 10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule